// File: doc/BRIEF.md
# Reference Clock Loss Monitor with Limp-Home Fallback

This block watches an external reference clock from a free-running backup clock domain. Reference transitions are brought into the backup domain through a flop synchronizer and turned into single-cycle edge pulses. While monitoring is armed, a timer counts backup cycles between those pulses. When the gap grows too long, the block declares the reference lost. It then moves the system onto the backup clock, which is limp-home mode. If limp-home is disabled, it raises a clock-failure reset request instead.

In limp-home mode the block counts reference edges in a qualification counter whose top bit marks success. Every further loss timeout resets the count to zero. Once the counter's top bit is set, the block leaves limp-home mode. It restores the source selection that was active just before the loss, keeping the PLL only if software still asks for it. Monitoring control then returns to the two monitor-enable bits. The block holds a six-bit control register with a write port. The actual oscillator, the PLL and the glitch-free clock multiplexer are elsewhere: the chosen source leaves the block only as a two-bit select code.

Top module: `clkmon_limp_ctrl`

## Requirements
- R1: After reset the control register reads 6'b000101, the limp flag and the failure request are low, the monitor state is high and the select is 2'b00. Control fields: bit0 monitor enable, bit1 fast monitor enable, bit2 PLL on, bit3 automatic PLL, bit4 PLL select, bit5 limp-home disable.
- R2: With bit0 or bit1 set and bit5 clear, limp-home mode is entered when the gap between two synchronized rising reference edges exceeds LOSS_CYCLES backup cycles. A gap of LOSS_CYCLES or fewer never enters it.
- R3: With bit0 and bit1 both clear, a stopped reference causes neither limp-home mode nor a failure request, and the monitor state output is low.
- R4: While in limp-home mode the limp flag is high, the select is 2'b10 (backup) and the monitor state is forced high whatever bit0 and bit1 hold. Outside limp-home mode the select is never 2'b10.
- R5: Limp-home mode ends on the 2^(QUAL_BITS-1)-th synchronized rising reference edge counted since entry, and not on an earlier one.
- R6: A loss timeout during limp-home mode clears the qualification count, so a full 2^(QUAL_BITS-1) fresh edges are needed after it.
- R7: The select outside limp-home mode is 2'b01 (PLL) when bits 2, 3 and 4 are all set, otherwise 2'b00 (reference). On exit, a selection of 2'b01 held just before the loss is restored.
- R8: If bit4 is cleared during limp-home mode, the select on exit is 2'b00.
- R9: Outside limp-home mode the monitor state equals bit0 OR bit1, including right after exit.
- R10: With bit5 set, a loss raises the failure request instead of limp-home mode. The request stays high until reset, and the select is left unchanged.
- R11: A write with the write enable high loads the written value into the control register, which reads it back from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bk_clk | input | 1 | Free-running backup clock; all state is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Raw external reference clock, asynchronous to bk_clk |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 6 | Control register write value |
| ctl_q | output | 6 | Control register contents |
| clk_sel | output | 2 | Source select: 00 reference, 01 PLL, 10 backup |
| limp_flag | output | 1 | High exactly while in limp-home mode |
| mon_state | output | 1 | High while the loss monitor is armed |
| fail_rst_req | output | 1 | Clock-failure reset request, held until reset |

## Verification
Several properties are checked on every cycle:
- The backup select and the forced monitor state go together with the limp flag.
- Outside limp-home mode, the monitor state follows the enable bits.
- Entry into limp-home mode only follows cycles with an armed monitor and limp-home enabled.
- The failure request is sticky and never coexists with limp-home mode.
- A cleared PLL select yields the reference on exit.
- A register write is visible on the next cycle.

The bench scenarios cover the rest:
- The exact loss threshold, swept across all half-periods up to the timeout.
- The exact qualification edge count.
- The clearing of the count by a timeout in mid-qualification.
- The restoration of a PLL selection.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   typedef enum logic [1:0] {
      SRC_REF    = 2'b00,
      SRC_PLL    = 2'b01,
      SRC_BACKUP = 2'b10
   } clk_src_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_LIMP = 2'b01,
      ST_FAIL = 2'b10
   } lh_state_e;

   typedef struct packed {
      logic lh_dis;
      logic pll_sel;
      logic auto_pll;
      logic pll_on;
      logic fast_mon;
      logic mon_en;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   localparam ctl_t CTL_RST = '{lh_dis: 1'b0, pll_sel: 1'b0, auto_pll: 1'b0,
                                pll_on: 1'b1, fast_mon: 1'b0, mon_en: 1'b1};

   function automatic clk_src_e pick_src(input ctl_t c);
      return (c.auto_pll && c.pll_sel && c.pll_on) ? SRC_PLL : SRC_REF;
   endfunction

endpackage

// File: rtl/clkmon_sync_edge.sv
module clkmon_sync_edge #(
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_MODE   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("clkmon_sync_edge: SYNC_STAGES must be at least 2");
   end
   if (EDGE_MODE != 0 && EDGE_MODE != 1) begin : g_bad_mode
      $error("clkmon_sync_edge: EDGE_MODE must be 0 or 1");
   end

   logic [SYNC_STAGES-1:0] shr_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr_q  <= '0;
         last_q <= 1'b0;
      end else begin
         shr_q  <= {shr_q[SYNC_STAGES-2:0], async_in};
         last_q <= shr_q[SYNC_STAGES-1];
      end
   end

   if (EDGE_MODE == 0) begin : g_rise
      assign edge_o = shr_q[SYNC_STAGES-1] & ~last_q;
   end else begin : g_both
      assign edge_o = shr_q[SYNC_STAGES-1] ^ last_q;
   end
endmodule

// File: rtl/clkmon_loss_timer.sv
module clkmon_loss_timer #(
   parameter int LOSS_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic edge_seen,
   output logic timeout
);
   localparam int CW = (LOSS_CYCLES > 2) ? $clog2(LOSS_CYCLES) : 1;

   if (LOSS_CYCLES < 4) begin : g_bad_loss
      $error("clkmon_loss_timer: LOSS_CYCLES must be at least 4");
   end

   logic [CW-1:0] gap_q;

   assign timeout = arm && !edge_seen && (gap_q == CW'(LOSS_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
      end else if (!arm || edge_seen || timeout) begin
         gap_q <= '0;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end
endmodule

// File: rtl/clkmon_qual_cnt.sv
module clkmon_qual_cnt #(
   parameter int QUAL_BITS = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic reached
);
   if (QUAL_BITS < 2) begin : g_bad_bits
      $error("clkmon_qual_cnt: QUAL_BITS must be at least 2");
   end

   logic [QUAL_BITS-1:0] cnt_q;
   logic [QUAL_BITS-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;
   assign reached = inc && !clr && cnt_nxt[QUAL_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/clkmon_limp_ctrl.sv
module clkmon_limp_ctrl
   import clkmon_pkg::*;
#(
   parameter int LOSS_CYCLES = 64,
   parameter int QUAL_BITS   = 13,
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_MODE   = 0
) (
   input  logic                   bk_clk,
   input  logic                   rst_n,
   input  logic                   ref_clk_in,
   input  logic                   cfg_we,
   input  logic [CTL_W-1:0]       cfg_wdata,
   output logic [CTL_W-1:0]       ctl_q,
   output logic [1:0]             clk_sel,
   output logic                   limp_flag,
   output logic                   mon_state,
   output logic                   fail_rst_req
);
   if (CTL_W != 6) begin : g_bad_ctl
      $error("clkmon_limp_ctrl: control layout must be six bits");
   end

   ctl_t      ctl_r;
   lh_state_e state_q;
   clk_src_e  sel_q;
   clk_src_e  saved_q;
   logic      ref_edge;
   logic      loss_evt;
   logic      qual_done;
   logic      in_limp;
   logic      mon_on;

   // control register
   always_ff @(posedge bk_clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_r <= CTL_RST;
      end else if (cfg_we) begin
         ctl_r <= ctl_t'(cfg_wdata);
      end
   end

   assign in_limp = (state_q == ST_LIMP);
   assign mon_on  = in_limp || ctl_r.mon_en || ctl_r.fast_mon;

   clkmon_sync_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .EDGE_MODE   (EDGE_MODE)
   ) u_sync (
      .clk      (bk_clk),
      .rst_n    (rst_n),
      .async_in (ref_clk_in),
      .edge_o   (ref_edge)
   );

   clkmon_loss_timer #(
      .LOSS_CYCLES (LOSS_CYCLES)
   ) u_timer (
      .clk       (bk_clk),
      .rst_n     (rst_n),
      .arm       (mon_on && (state_q != ST_FAIL)),
      .edge_seen (ref_edge),
      .timeout   (loss_evt)
   );

   clkmon_qual_cnt #(
      .QUAL_BITS (QUAL_BITS)
   ) u_qual (
      .clk     (bk_clk),
      .rst_n   (rst_n),
      .clr     (!in_limp || loss_evt),
      .inc     (in_limp && ref_edge),
      .reached (qual_done)
   );

   // mode sequencing and source memory
   always_ff @(posedge bk_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         sel_q   <= SRC_REF;
         saved_q <= SRC_REF;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               sel_q <= pick_src(ctl_r);
               if (loss_evt) begin
                  if (ctl_r.lh_dis) begin
                     state_q <= ST_FAIL;
                  end else begin
                     state_q <= ST_LIMP;
                     saved_q <= sel_q;
                  end
               end
            end
            ST_LIMP: begin
               if (qual_done) begin
                  state_q <= ST_RUN;
                  sel_q   <= (saved_q == SRC_PLL) ? pick_src(ctl_r) : SRC_REF;
               end
            end
            ST_FAIL: begin
               state_q <= ST_FAIL;
            end
            default: begin
               state_q <= ST_RUN;
            end
         endcase
      end
   end

   assign ctl_q        = ctl_r;
   assign limp_flag    = in_limp;
   assign clk_sel      = in_limp ? SRC_BACKUP : sel_q;
   assign mon_state    = mon_on;
   assign fail_rst_req = (state_q == ST_FAIL);
endmodule

// File: rtl/clkmon_limp_chk.sv
module clkmon_limp_chk (
   input logic       bk_clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [5:0] cfg_wdata,
   input logic [5:0] ctl_q,
   input logic [1:0] clk_sel,
   input logic       limp_flag,
   input logic       mon_state,
   input logic       fail_rst_req
);
   AST_LIMP_ON_BACKUP: assert property (@(posedge bk_clk) disable iff (!rst_n)
      limp_flag |-> (clk_sel == 2'b10) && mon_state); // R4

   AST_RUN_NOT_BACKUP: assert property (@(posedge bk_clk) disable iff (!rst_n)
      !limp_flag |-> (clk_sel != 2'b10)); // R4

   AST_ENTRY_NEEDS_MON: assert property (@(posedge bk_clk) disable iff (!rst_n)
      $rose(limp_flag) |-> $past(ctl_q[0] | ctl_q[1])); // R3

   AST_ENTRY_NOT_DISABLED: assert property (@(posedge bk_clk) disable iff (!rst_n)
      $rose(limp_flag) |-> !$past(ctl_q[5])); // R2

   AST_EXIT_NO_PLL: assert property (@(posedge bk_clk) disable iff (!rst_n)
      ($fell(limp_flag) && !$past(ctl_q[4])) |-> (clk_sel == 2'b00)); // R8

   AST_MON_FOLLOWS_BITS: assert property (@(posedge bk_clk) disable iff (!rst_n)
      !limp_flag |-> (mon_state == (ctl_q[0] | ctl_q[1]))); // R9

   AST_FAIL_STICKY: assert property (@(posedge bk_clk) disable iff (!rst_n)
      fail_rst_req |=> fail_rst_req); // R10

   AST_FAIL_NO_LIMP: assert property (@(posedge bk_clk) disable iff (!rst_n)
      fail_rst_req |-> !limp_flag); // R10

   AST_WRITE_LANDS: assert property (@(posedge bk_clk) disable iff (!rst_n)
      cfg_we |=> (ctl_q == $past(cfg_wdata))); // R11
endmodule

bind clkmon_limp_ctrl clkmon_limp_chk u_chk (
   .bk_clk       (bk_clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_wdata    (cfg_wdata),
   .ctl_q        (ctl_q),
   .clk_sel      (clk_sel),
   .limp_flag    (limp_flag),
   .mon_state    (mon_state),
   .fail_rst_req (fail_rst_req)
);

// File: tb/sim_clkmon_limp_ctrl.sv
`timescale 1ns/1ps
module sim_clkmon_limp_ctrl;
   localparam int LOSS = 16;
   localparam int QB   = 6;
   localparam int QUAL = 1 << (QB - 1);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic [5:0] ctl_q;
   logic [1:0] clk_sel;
   logic       limp_flag;
   logic       mon_state;
   logic       fail_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   clkmon_limp_ctrl #(
      .LOSS_CYCLES (LOSS),
      .QUAL_BITS   (QB),
      .SYNC_STAGES (2),
      .EDGE_MODE   (0)
   ) u0 (
      .bk_clk       (clk),
      .rst_n        (rst_n),
      .ref_clk_in   (ref_in),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .ctl_q        (ctl_q),
      .clk_sel      (clk_sel),
      .limp_flag    (limp_flag),
      .mon_state    (mon_state),
      .fail_rst_req (fail_rst_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n  = 1'b0;
      ref_in = 1'b0;
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [5:0] v);
      cfg_wdata = v;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic pulse_ref(input int n, input int h);
      for (int i = 0; i < n; i++) begin
         ref_in = 1'b1;
         repeat (h) @(negedge clk);
         ref_in = 1'b0;
         repeat (h) @(negedge clk);
      end
   endtask

   task automatic wait_limp(input int max_cyc);
      for (int i = 0; i < max_cyc; i++) begin
         if (limp_flag) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual expired expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 ctl", ctl_q, 6'b000101);
      chk("R1 limp", limp_flag, 0);
      chk("R1 fail", fail_rst_req, 0);
      chk("R1 sel", clk_sel, 0);
      chk("R1 mon", mon_state, 1);

      // R11 every control value reads back
      for (int v = 0; v < 64; v++) begin
         wr(6'(v));
         chk("R11 readback", ctl_q, v);
      end

      // R2 sweep of reference half-periods across the loss threshold
      for (int h = 1; h <= LOSS; h++) begin
         do_reset();
         pulse_ref(8, h);
         chk($sformatf("R2 half=%0d", h), limp_flag, (2 * h > LOSS) ? 1 : 0);
      end

      // R3 monitor off, then fast monitor alone arms it
      do_reset();
      wr(6'h04);
      repeat (100) @(negedge clk);
      chk("R3 limp", limp_flag, 0);
      chk("R3 fail", fail_rst_req, 0);
      chk("R3 mon", mon_state, 0);
      wr(6'h06);
      wait_limp(LOSS + 10);
      chk("R2 fast monitor entry", limp_flag, 1);

      // R4 R5 R7 R9 PLL restore, monitor bits cleared in limp-home
      do_reset();
      wr(6'h1D);
      pulse_ref(2, 2);
      chk("R7 pll before loss", clk_sel, 1);
      wait_limp(LOSS + 10);
      chk("R4 limp", limp_flag, 1);
      chk("R4 backup sel", clk_sel, 2);
      wr(6'h1C);
      chk("R4 mon forced", mon_state, 1);
      pulse_ref(QUAL - 1, 2);
      repeat (3) @(negedge clk);
      chk("R5 one edge short", limp_flag, 1);
      pulse_ref(1, 2);
      repeat (3) @(negedge clk);
      chk("R5 exit", limp_flag, 0);
      chk("R7 pll restored", clk_sel, 1);
      chk("R9 mon after exit", mon_state, 0);

      // R8 PLL select cleared during limp-home
      do_reset();
      wr(6'h1D);
      pulse_ref(2, 2);
      wait_limp(LOSS + 10);
      chk("R8 limp", limp_flag, 1);
      wr(6'h0D);
      pulse_ref(QUAL, 2);
      repeat (3) @(negedge clk);
      chk("R8 exit", limp_flag, 0);
      chk("R8 ref sel", clk_sel, 0);
      chk("R9 mon after exit", mon_state, 1);

      // R6 timeout mid-qualification clears the count
      do_reset();
      pulse_ref(2, 2);
      wait_limp(LOSS + 10);
      chk("R6 limp", limp_flag, 1);
      pulse_ref(QUAL / 2, 2);
      repeat (LOSS + 6) @(negedge clk);
      pulse_ref(QUAL - 1, 2);
      repeat (3) @(negedge clk);
      chk("R6 count restarted", limp_flag, 1);
      pulse_ref(1, 2);
      repeat (3) @(negedge clk);
      chk("R6 exit", limp_flag, 0);
      chk("R7 ref restored", clk_sel, 0);

      // R10 limp-home disabled
      do_reset();
      wr(6'h25);
      pulse_ref(2, 2);
      repeat (LOSS + 20) @(negedge clk);
      chk("R10 fail", fail_rst_req, 1);
      chk("R10 no limp", limp_flag, 0);
      chk("R10 sel kept", clk_sel, 0);
      pulse_ref(4, 2);
      chk("R10 sticky", fail_rst_req, 1);
      do_reset();
      chk("R10 cleared by reset", fail_rst_req, 0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule